// File: doc/BRIEF.md
# Aligned Word/Burst Buffer Transfer Sequencer

This block runs the memory side of one packet transfer between a word FIFO and a buffer in memory. A command gives a start word address, a word count and a direction. The sequencer issues single-word requests until the address reaches a four-word boundary. It then issues four-word burst requests while at least four buffer words remain, and it moves the last zero to three words as single requests. The memory side answers each request with an acknowledge. Data moves between the FIFO and memory outside this block, and the block only sequences the transfers.

In receive mode the attention input marks the end of the packet. The sequencer works out how many words remain, allowing for the trailing CRC word and for the excess-word field of the status input. When the buffer fills exactly, it reads and discards one more FIFO word, which shows whether that word was the CRC or whether the packet overflowed. In transmit mode, after the last word it issues an end-of-packet state command and waits for attention. Every command ends with a one-cycle completion pulse. The pulse carries an end word count and a post word: a post code in the upper byte and the inverted, masked status in the lower byte.

Top module: `xfer_seq`

## Requirements
- R1: While the request address is not a multiple of 4 and words remain, each request is a single word (`mem_quad`=0). The number of such leading singles is min((−start) mod 4, count).
- R2: When the address is a multiple of 4 and at least 4 words remain, the request is a burst (`mem_quad`=1) at that aligned address, and it advances the address by 4 and the remaining count by 4.
- R3: The last 0 to 3 words go as single requests at consecutive addresses, each advancing by 1. In transmit mode, and in receive mode without attention, every word of the count is requested.
- R4: A count of zero produces no memory request. Completion follows one cycle after the start, with end count 0 and post word 0x04FF.
- R5: In receive mode, if attention is high when the next request would be a burst, the transfer ends. The end count is remaining words + 1 + status[7:6], and the post code is 0.
- R6: In receive mode, if attention is high when the next request would be a single, the transfer ends. The end count is remaining words + 1, and the post code is 0.
- R7: In receive mode, when the buffer is exactly full: if attention is already high, completion has code 0 and count 0. Otherwise one discard read is issued (`mem_discard`=1, single). Attention after that read gives code 0. No attention gives code 2, post word 0x02FF. The count is 0 in every case.
- R8: The post word is {code, ~((status[15:8]) & mask)}. The receive mask is 0x29 and the transmit mask is 0x50.
- R9: In transmit mode, after the last word `state_cmd_valid` pulses for one cycle with `state_cmd`=0x47. The block then waits for attention and completes with code 1 and count 0. Attention during a transmit transfer ends it with code 1 and end count = remaining words.
- R10: `cmd_abort` ends any state, including idle, on the next cycle with code 5, count 0 and post word 0x05F9. No further request is issued. Abort takes priority over start.
- R11: A start pulse while a transfer is in progress is ignored.
- R12: After reset no request, state command or completion is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start pulse, accepted only when idle |
| cmd_tx | input | 1 | Direction: 1 transmit (memory to FIFO), 0 receive |
| cmd_abort | input | 1 | Abort the current command and post |
| cmd_ptr | input | AW | Buffer start word address |
| cmd_count | input | CW | Buffer length in words |
| mem_req | output | 1 | Transfer request valid |
| mem_quad | output | 1 | Request is a four-word burst |
| mem_discard | output | 1 | FIFO read whose word is dropped, not stored |
| mem_we | output | 1 | Request writes memory (receive direction) |
| mem_addr | output | AW | Request word address |
| mem_ack | input | 1 | Request accepted this cycle |
| attn | input | 1 | End-of-packet or error attention |
| status | input | 16 | Interface status; [15:8] error flags, [7:6] excess words |
| state_cmd_valid | output | 1 | State command strobe |
| state_cmd | output | 8 | State command value |
| done_o | output | 1 | Completion pulse |
| done_count | output | CW | End word count |
| done_post | output | 16 | Post word: code, inverted masked status |

## Verification
The bound checker watches every cycle for the following: a burst is never issued at an unaligned address or with fewer than four words left, each accepted request advances the address by its own size, a discard read is never a burst, the state command always carries the end-of-packet value, no request is raised in a completion cycle, and an abort always leads to an abort post. Several things only the bench scenarios can show. These are the exact number of leading singles for each start alignment, the end-count arithmetic that includes the excess field, the choice between a CRC word and an overflow after an exact fill, the masked status bytes, and that a start is ignored while busy. The bench checks them by replaying each request sequence against its own model and adding random acknowledge stalls.

// File: rtl/xseq_pkg.sv
package xseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_XFER,
      ST_FULL,
      ST_DRAIN,
      ST_CHECK,
      ST_EOP,
      ST_WAIT
   } seq_state_e;

   typedef enum logic [1:0] {
      SRC_NONE,
      SRC_RX,
      SRC_TX,
      SRC_CMD
   } low_src_e;

   localparam logic [7:0] PC_RX_DONE  = 8'd0;
   localparam logic [7:0] PC_TX_DONE  = 8'd1;
   localparam logic [7:0] PC_RX_OVF   = 8'd2;
   localparam logic [7:0] PC_ZERO     = 8'd4;
   localparam logic [7:0] PC_ABORT    = 8'd5;

   localparam logic [7:0] RX_MASK     = 8'h29;
   localparam logic [7:0] TX_MASK     = 8'h50;
   localparam logic [7:0] CMD_FLAGS   = 8'h06;
   localparam logic [7:0] EOP_CMD     = 8'h47;

endpackage

// File: rtl/xseq_step.sv
module xseq_step #(
   parameter int AW    = 16,
   parameter int CW    = 16,
   parameter int BURST = 4
) (
   input  logic [AW-1:0] addr,
   input  logic [CW-1:0] rem,
   output logic          quad,
   output logic [AW-1:0] next_addr,
   output logic [CW-1:0] next_rem,
   output logic          last
);
   localparam int LB = $clog2(BURST);

   generate
      if ((1 << LB) != BURST || LB < 1) begin : g_bad_burst
         $error("BURST must be a power of two of at least 2");
      end
      if (AW <= LB || CW <= LB) begin : g_bad_width
         $error("AW and CW must exceed the burst index width");
      end
   endgenerate

   logic aligned;
   logic [CW-1:0] step_c;

   assign aligned   = (addr[LB-1:0] == '0);
   assign quad      = aligned && (rem >= CW'(BURST));
   assign step_c    = quad ? CW'(BURST) : CW'(1);
   assign next_addr = addr + AW'(step_c);
   assign next_rem  = rem - step_c;
   assign last      = (next_rem == '0);

endmodule

// File: rtl/xseq_post.sv
module xseq_post
   import xseq_pkg::*;
#(
   parameter int SW = 16
) (
   input  logic [7:0]    code,
   input  low_src_e      src,
   input  logic [SW-1:0] status,
   output logic [15:0]   post
);
   generate
      if (SW != 16) begin : g_bad_sw
         $error("status width must be 16");
      end
   endgenerate

   logic [7:0] flags;
   logic [7:0] masked;
   logic       unused_low;

   assign flags      = status[15:8];
   assign unused_low = &{1'b0, status[7:0]};

   always_comb begin
      unique case (src)
         SRC_RX:  masked = flags & RX_MASK;
         SRC_TX:  masked = flags & TX_MASK;
         SRC_CMD: masked = CMD_FLAGS;
         default: masked = 8'h00;
      endcase
   end

   assign post = {code, ~masked};

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
   import xseq_pkg::*;
#(
   parameter int AW    = 16,
   parameter int CW    = 16,
   parameter int BURST = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_start,
   input  logic          cmd_tx,
   input  logic          cmd_abort,
   input  logic [AW-1:0] cmd_ptr,
   input  logic [CW-1:0] cmd_count,
   output logic          mem_req,
   output logic          mem_quad,
   output logic          mem_discard,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_ack,
   input  logic          attn,
   input  logic [15:0]   status,
   output logic          state_cmd_valid,
   output logic [7:0]    state_cmd,
   output logic          done_o,
   output logic [CW-1:0] done_count,
   output logic [15:0]   done_post
);
   seq_state_e    st_q, st_d;
   logic [AW-1:0] addr_q, addr_d;
   logic [CW-1:0] rem_q, rem_d;
   logic          tx_q, tx_d;

   logic          step_quad, step_last;
   logic [AW-1:0] step_addr;
   logic [CW-1:0] step_rem;

   logic          fin;
   logic [7:0]    fin_code;
   logic [CW-1:0] fin_cnt;
   low_src_e      fin_src;
   logic [15:0]   post_w;
   logic [CW-1:0] excess;
   logic          unused_status;

   assign excess        = CW'(status[7:6]);
   assign unused_status = &{1'b0, status[5:0]};

   xseq_step #(.AW(AW), .CW(CW), .BURST(BURST)) step_i (
      .addr      (addr_q),
      .rem       (rem_q),
      .quad      (step_quad),
      .next_addr (step_addr),
      .next_rem  (step_rem),
      .last      (step_last)
   );

   xseq_post #(.SW(16)) post_i (
      .code   (fin_code),
      .src    (fin_src),
      .status (status),
      .post   (post_w)
   );

   always_comb begin
      st_d     = st_q;
      addr_d   = addr_q;
      rem_d    = rem_q;
      tx_d     = tx_q;
      fin      = 1'b0;
      fin_code = PC_RX_DONE;
      fin_cnt  = '0;
      fin_src  = SRC_NONE;
      if (cmd_abort) begin
         fin      = 1'b1;
         fin_code = PC_ABORT;
         fin_src  = SRC_CMD;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (cmd_start) begin
                  addr_d = cmd_ptr;
                  rem_d  = cmd_count;
                  tx_d   = cmd_tx;
                  if (cmd_count == '0) begin
                     fin      = 1'b1;
                     fin_code = PC_ZERO;
                  end else begin
                     st_d = ST_XFER;
                  end
               end
            end
            ST_XFER: begin
               if (attn) begin
                  fin = 1'b1;
                  if (tx_q) begin
                     fin_code = PC_TX_DONE;
                     fin_cnt  = rem_q;
                     fin_src  = SRC_TX;
                  end else begin
                     fin_code = PC_RX_DONE;
                     fin_cnt  = rem_q + CW'(1) + (step_quad ? excess : '0);
                     fin_src  = SRC_RX;
                  end
               end else if (mem_ack) begin
                  addr_d = step_addr;
                  rem_d  = step_rem;
                  if (step_last) st_d = tx_q ? ST_EOP : ST_FULL;
               end
            end
            ST_FULL: begin
               if (attn) begin
                  fin     = 1'b1;
                  fin_src = SRC_RX;
               end else begin
                  st_d = ST_DRAIN;
               end
            end
            ST_DRAIN: begin
               if (mem_ack) st_d = ST_CHECK;
            end
            ST_CHECK: begin
               fin = 1'b1;
               if (attn) begin
                  fin_src = SRC_RX;
               end else begin
                  fin_code = PC_RX_OVF;
               end
            end
            ST_EOP: st_d = ST_WAIT;
            ST_WAIT: begin
               if (attn) begin
                  fin      = 1'b1;
                  fin_code = PC_TX_DONE;
                  fin_src  = SRC_TX;
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end
      if (fin) st_d = ST_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         addr_q     <= '0;
         rem_q      <= '0;
         tx_q       <= 1'b0;
         done_o     <= 1'b0;
         done_count <= '0;
         done_post  <= '0;
      end else begin
         st_q   <= st_d;
         addr_q <= addr_d;
         rem_q  <= rem_d;
         tx_q   <= tx_d;
         done_o <= fin;
         if (fin) begin
            done_count <= fin_cnt;
            done_post  <= post_w;
         end
      end
   end

   assign mem_req         = ((st_q == ST_XFER) && !attn) || (st_q == ST_DRAIN);
   assign mem_quad        = (st_q == ST_XFER) && step_quad;
   assign mem_discard     = (st_q == ST_DRAIN);
   assign mem_we          = !tx_q;
   assign mem_addr        = addr_q;
   assign state_cmd_valid = (st_q == ST_EOP);
   assign state_cmd       = EOP_CMD;

endmodule

// File: rtl/xseq_chk.sv
module xseq_chk #(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_quad,
   input logic          mem_discard,
   input logic [AW-1:0] mem_addr,
   input logic          mem_ack,
   input logic          cmd_abort,
   input logic          state_cmd_valid,
   input logic [7:0]    state_cmd,
   input logic          done_o,
   input logic [15:0]   done_post,
   input logic [CW-1:0] rem
);
   p_quad_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_quad) |-> (mem_addr[1:0] == 2'b00));

   p_quad_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_quad) |-> (rem >= CW'(4)));

   p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && !mem_discard && !cmd_abort) |=>
      (mem_addr == $past(mem_addr) + ($past(mem_quad) ? AW'(4) : AW'(1))));

   p_discard_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_discard |-> !mem_quad);

   p_eop_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
      state_cmd_valid |-> (state_cmd == 8'h47));

   p_abort_posts_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_abort |=> (done_o && done_post == 16'h05F9));

   p_done_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!mem_req && !state_cmd_valid));

endmodule

bind xfer_seq xseq_chk #(.AW(AW), .CW(CW)) chk_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .mem_req         (mem_req),
   .mem_quad        (mem_quad),
   .mem_discard     (mem_discard),
   .mem_addr        (mem_addr),
   .mem_ack         (mem_ack),
   .cmd_abort       (cmd_abort),
   .state_cmd_valid (state_cmd_valid),
   .state_cmd       (state_cmd),
   .done_o          (done_o),
   .done_post       (done_post),
   .rem             (rem_q)
);

// File: tb/xfer_seq_tb_top.sv
module xfer_seq_tb_top;
   localparam int AW = 16;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_start = 1'b0, cmd_tx = 1'b0, cmd_abort = 1'b0;
   logic [AW-1:0] cmd_ptr = '0;
   logic [CW-1:0] cmd_count = '0;
   logic          mem_req, mem_quad, mem_discard, mem_we;
   logic [AW-1:0] mem_addr;
   logic          mem_ack = 1'b0;
   logic          attn = 1'b0;
   logic [15:0]   status = '0;
   logic          state_cmd_valid;
   logic [7:0]    state_cmd;
   logic          done_o;
   logic [CW-1:0] done_count;
   logic [15:0]   done_post;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   xfer_seq #(.AW(AW), .CW(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_tx(cmd_tx),
      .cmd_abort(cmd_abort), .cmd_ptr(cmd_ptr), .cmd_count(cmd_count),
      .mem_req(mem_req), .mem_quad(mem_quad), .mem_discard(mem_discard),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack), .attn(attn),
      .status(status), .state_cmd_valid(state_cmd_valid), .state_cmd(state_cmd),
      .done_o(done_o), .done_count(done_count), .done_post(done_post)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // number of requests the model expects for a buffer
   function automatic int n_xfers(input int ptr, input int cnt);
      int a = ptr, r = cnt, n = 0;
      while (r > 0) begin
         if ((a % 4) == 0 && r >= 4) begin a += 4; r -= 4; end
         else begin a += 1; r -= 1; end
         n++;
      end
      return n;
   endfunction

   // remaining words and burst flag before request k
   function automatic int rem_before(input int ptr, input int cnt, input int k,
                                     output bit quad);
      int a = ptr, r = cnt;
      for (int i = 0; i < k; i++) begin
         if ((a % 4) == 0 && r >= 4) begin a += 4; r -= 4; end
         else begin a += 1; r -= 1; end
      end
      quad = ((a % 4) == 0 && r >= 4);
      return r;
   endfunction

   function automatic logic [7:0] low_byte(input logic [15:0] st, input logic [7:0] mask);
      return ~(st[15:8] & mask);
   endfunction

   task automatic run(input bit tx, input int ptr, input int cnt, input int stop_at,
                      input int abort_at, input int busy_at);
      int ntr, k, ea, er, exp_cnt, rem_k;
      logic [15:0] st, exp_post;
      bit q_k, eop_seen, got, exp_q;
      string tag, rtag;
      st = 16'($urandom);
      status = st;
      ntr = n_xfers(ptr, cnt);
      if (abort_at >= 0) begin
         exp_cnt = 0; exp_post = 16'h05F9; rtag = "R10";
      end else if (cnt == 0) begin
         exp_cnt = 0; exp_post = 16'h04FF; rtag = "R4";
      end else if (tx) begin
         rtag = "R9";
         exp_post = {8'd1, low_byte(st, 8'h50)};
         if (stop_at < ntr) exp_cnt = rem_before(ptr, cnt, stop_at, q_k);
         else exp_cnt = 0;
      end else if (stop_at < ntr) begin
         rem_k = rem_before(ptr, cnt, stop_at, q_k);
         exp_cnt = rem_k + 1 + (q_k ? int'(st[7:6]) : 0);
         exp_post = {8'd0, low_byte(st, 8'h29)};
         rtag = q_k ? "R5" : "R6";
      end else if (stop_at <= ntr + 1) begin
         exp_cnt = 0; exp_post = {8'd0, low_byte(st, 8'h29)}; rtag = "R7";
      end else begin
         exp_cnt = 0; exp_post = 16'h02FF; rtag = "R7";
      end

      @(negedge clk);
      cmd_tx = tx; cmd_ptr = AW'(ptr); cmd_count = CW'(cnt); cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      ea = ptr; er = cnt; k = 0; eop_seen = 0; got = 0;
      for (int cyc = 0; cyc < 400 && !got; cyc++) begin
         if (tx) attn = ((stop_at < ntr) && (k >= stop_at)) || eop_seen;
         else attn = (k >= stop_at);
         cmd_abort = (cyc == abort_at);
         cmd_start = (cyc == busy_at);
         if (cyc == busy_at) begin cmd_ptr = AW'(ptr ^ 5); cmd_count = CW'(7); end
         mem_ack = 1'b0;
         #1;
         if (done_o) begin
            got = 1;
            chk(done_count == CW'(exp_cnt), rtag, "end count", done_count, exp_cnt);
            chk(done_post == exp_post, (rtag == "R5" || rtag == "R6") ? "R8" : rtag,
                "post word", done_post, exp_post);
            if (abort_at < 0 && stop_at >= ntr)
               chk(k >= ntr, "R3", "all words requested", k, ntr);
         end else begin
            if (state_cmd_valid) begin
               chk(state_cmd == 8'h47, "R9", "state command", state_cmd, 8'h47);
               chk(tx && k == ntr, "R9", "eop after last word", k, ntr);
               eop_seen = 1;
            end
            if (mem_req && !cmd_abort) begin
               if (k < ntr) begin
                  exp_q = ((ea % 4) == 0 && er >= 4);
                  tag = ((ea % 4) != 0) ? "R1" : (exp_q ? "R2" : "R3");
                  chk(mem_addr == AW'(ea), tag, "request address", mem_addr, ea);
                  chk(mem_quad == exp_q, tag, "burst flag", mem_quad, exp_q);
                  chk(!mem_discard && mem_we == !tx, tag, "request kind",
                      {mem_discard, mem_we}, {1'b0, !tx});
               end else begin
                  chk(!tx && mem_discard && !mem_quad, "R7", "discard read",
                      {mem_discard, mem_quad}, 2'b10);
               end
               if (($urandom % 3) != 0) begin
                  mem_ack = 1'b1;
                  if (k < ntr) begin
                     if ((ea % 4) == 0 && er >= 4) begin ea += 4; er -= 4; end
                     else begin ea += 1; er -= 1; end
                  end
                  k++;
               end
            end
            @(negedge clk);
         end
      end
      if (!got) chk(1'b0, rtag, "no completion", 0, 1);
      attn = 1'b0; cmd_abort = 1'b0; cmd_start = 1'b0; mem_ack = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      #1;
      chk(!mem_req && !done_o && !state_cmd_valid, "R12", "outputs in reset",
          {mem_req, done_o, state_cmd_valid}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(!mem_req && !done_o && !state_cmd_valid, "R12", "outputs after reset",
          {mem_req, done_o, state_cmd_valid}, 0);

      // directed corners
      run(0, 5, 0, 1000, -1, -1);        // R4 receive, zero count
      run(1, 6, 0, 1000, -1, -1);        // R4 transmit
      run(0, 1, 13, 1000, -1, -1);       // R1 R3 R7 overflow
      run(0, 0, 8, 2, -1, -1);           // R7 attention at exact fill
      run(0, 2, 10, 5, -1, -1);          // R7 attention after discard read
      run(0, 3, 20, 2, -1, -1);          // R5 attention in burst phase
      run(0, 1, 6, 1, -1, -1);           // R6 attention in single phase
      run(1, 2, 11, 1000, -1, -1);       // R9 normal transmit
      run(1, 0, 12, 1, -1, -1);          // R8 R9 transmit attention mid-way
      run(0, 0, 16, 1000, 3, -1);        // R10 abort mid transfer
      run(0, 4, 16, 1000, -1, 1);        // R11 start while busy

      // R10 abort while idle
      @(negedge clk);
      cmd_abort = 1'b1;
      @(negedge clk);
      cmd_abort = 1'b0;
      #1;
      chk(done_o && done_post == 16'h05F9 && done_count == '0, "R10", "idle abort",
          done_post, 16'h05F9);
      @(negedge clk);

      // constrained random
      for (int i = 0; i < 60; i++) begin
         int p, c, n, s;
         p = int'($urandom % 64);
         c = int'($urandom % 22);
         n = n_xfers(p, c);
         s = int'($urandom % (n + 3));
         run(1'($urandom % 2), p, c, s, -1, -1);
      end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule